// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one input-capture lane of a general-purpose timer. An asynchronous pin is brought into the clock domain and then debounced by a digital filter. The filter advances on a sample strobe that comes from the timer's own sampling clock generator, so the pin is judged at a rate that is independent of how fast the counter runs. An edge detector turns the filtered level into rising and falling pulses, and a polarity bit picks which of the two counts. The channel can capture on its own pin, on the neighbouring channel's pin, or on an internal trigger line.

The chosen event stream goes through a divide-by-1/2/4/8 prescaler. Every event that survives copies the free-running counter value into a shadow register. The value then moves to the host-visible capture register unless a host read is under way in that cycle. A capture flag and an overcapture flag tell the host that fresh data has arrived and whether data was lost. The own pin's edge-selected pulse is also driven out as a trigger for neighbouring logic.

Top module: `tmr_capture_chan`

## Requirements
- R1: Each pin passes two synchronizer flops and then a filter. The filtered level takes a new value only after that value has been sampled on N = cfg_filt+1 consecutive sample strobes. With cfg_filt=0 the filter samples on every clock and ignores the strobe. A pin pulse seen on fewer than N strobes never reaches the filtered level.
- R2: cfg_pol=0 selects rising edges of the filtered pin level and cfg_pol=1 selects falling edges. The same bit applies to both pin sources.
- R3: cfg_src selects the capture source: 2'b01 selects the own pin, 2'b10 the partner pin, 2'b11 trig_in. An event on a source that is not selected causes no capture.
- R4: cfg_psc sets the prescaler division: 2'b00 passes every event, 2'b01 every 2nd, 2'b10 every 4th and 2'b11 every 8th. Counting starts from the last prescaler clear, so the D-th event after a clear is the first one to capture, where D is the division.
- R5: The prescaler event count is cleared in three cases: in any cycle with cfg_cap_en=0, in any cycle with cfg_src=2'b00, and in the cycle after cfg_psc changes value.
- R6: With cfg_src=2'b00 (output mode) no capture occurs.
- R7: With cfg_cap_en=0 no capture occurs.
- R8: A capture stores the cnt_val present in the event cycle into the shadow register. cap_val takes that value on the following clock edge, unless rd_strobe is high in that cycle, in which case the move waits one cycle. For trig_in the new value is visible two edges after the trigger cycle. For a pin source it is visible N+3 edges after the first clock edge that samples the new pin level, and the stored value is cnt_val from the edge N+2 edges after that first sampling edge.
- R9: cap_flag is set on the edge that updates cap_val. It stays set until a cycle with rd_strobe=1, which clears it.
- R10: ovr_flag is set when cap_val is updated while cap_flag is still set. It stays set until ovr_clr=1.
- R11: trig_out pulses for one cycle on each own-pin edge selected by cfg_pol. It does so whatever the values of cfg_src and cfg_cap_en.
- R12: After reset, cap_val, cap_flag, ovr_flag and trig_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Filter sample strobe from the sampling clock generator |
| pin_own | input | 1 | This channel's asynchronous input pin |
| pin_partner | input | 1 | Neighbouring channel's asynchronous input pin |
| trig_in | input | 1 | Internal trigger pulse, synchronous to clk |
| cnt_val | input | CNT_W | Free-running counter value |
| cfg_filt | input | FILT_W | Filter length code |
| cfg_pol | input | 1 | Edge polarity, 0 rising, 1 falling |
| cfg_src | input | 2 | Capture source select |
| cfg_psc | input | PSC_W | Event prescaler code |
| cfg_cap_en | input | 1 | Capture enable |
| rd_strobe | input | 1 | Host read of the capture register |
| ovr_clr | input | 1 | Clear for the overcapture flag |
| cap_val | output | CNT_W | Host-visible capture register |
| cap_flag | output | 1 | New capture available |
| ovr_flag | output | 1 | Capture overwritten before it was read |
| trig_out | output | 1 | Own-pin edge-selected trigger pulse |

## Verification
The bench sends pin pulses that are one sample short of the filter length, both with the strobe on every cycle and with the strobe slowed down. A filter that counts clocks instead of strobes, or that miscounts by one, would capture on those glitches. It checks the exact counter value stored for pin and trigger events, so an extra or missing pipeline stage shows up as an off-by-one value. It also holds a read across the transfer cycle, where a design without the deferral would change the value during the read. Prescaler runs are cut short by disabling capture or by changing the division. A counter that is not cleared would then capture on the wrong event, and a random run that mixes divisions, reads and flag clears compares every capture against a bench model.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int TCC_CNT_W  = 16;
    localparam int TCC_FILT_W = 4;
    localparam int TCC_PSC_W  = 2;
    localparam int TCC_NUM_IN = 2;

    typedef enum logic [1:0] {
        SRC_OUTPUT  = 2'b00,
        SRC_OWN     = 2'b01,
        SRC_PARTNER = 2'b10,
        SRC_TRIG    = 2'b11
    } src_e;

    // Index of each pin inside the packed pin vector of the top module.
    localparam int PIN_OWN     = 0;
    localparam int PIN_PARTNER = 1;

endpackage

// File: rtl/tcc_in_filter.sv
// Pin conditioner: two-flop synchronizer, run-length filter, edge pulses.
module tcc_in_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              pin,
    input  logic [FILT_W-1:0] cfg_filt,
    output logic              lvl,
    output logic              rise,
    output logic              fall
);

    localparam int RUN_W = FILT_W + 1;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic             prev;
        logic [RUN_W-1:0] run;
    } flt_st_t;

    flt_st_t          st_q, st_d;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;
    logic             step;

    always_comb begin
        need    = RUN_W'(cfg_filt) + RUN_W'(1);
        run_inc = st_q.run + RUN_W'(1);
        step    = sample_tick || (cfg_filt == '0);

        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.lvl;

        if (step) begin
            if (st_q.s2 == st_q.lvl) begin
                st_d.run = '0;
            end else if (run_inc == need) begin
                st_d.lvl = st_q.s2;
                st_d.run = '0;
            end else begin
                st_d.run = run_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.lvl;
    assign rise = st_q.lvl & ~st_q.prev;
    assign fall = ~st_q.lvl & st_q.prev;

endmodule

// File: rtl/tcc_prescaler.sv
// Event divider: lets through every 2**cfg_psc-th event after a clear.
module tcc_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  evt,
    input  logic [PSC_W-1:0]      cfg_psc,
    output logic                  fire,
    output logic [(2**PSC_W)-2:0] ev_cnt
);

    localparam int DIV_W = (2 ** PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [PSC_W-1:0] prev;
    } psc_st_t;

    psc_st_t          st_q, st_d;
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] base;
    logic             restart;

    always_comb begin
        lim     = DIV_W'((32'd1 << cfg_psc) - 32'd1);
        restart = clr || (cfg_psc != st_q.prev);
        base    = restart ? '0 : st_q.cnt;

        st_d      = st_q;
        st_d.prev = cfg_psc;
        st_d.cnt  = base;
        fire      = 1'b0;

        if (evt) begin
            if (base == lim) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = base + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_cnt = st_q.cnt;

endmodule

// File: rtl/tcc_capture_reg.sv
// Shadow and visible capture registers with capture and overcapture flags.
module tcc_capture_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             rd_strobe,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] vis;
        logic             pend;
        logic             flag;
        logic             ovr;
    } cap_st_t;

    cap_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;

        if (ovr_clr) begin
            st_d.ovr = 1'b0;
        end

        // Move shadow to the visible register unless the host is reading.
        if (st_q.pend && !rd_strobe) begin
            st_d.vis  = st_q.shadow;
            st_d.pend = 1'b0;
            st_d.flag = 1'b1;
            if (st_q.flag) begin
                st_d.ovr = 1'b1;
            end
        end else if (rd_strobe) begin
            st_d.flag = 1'b0;
        end

        if (fire) begin
            st_d.shadow = cnt_val;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_val  = st_q.vis;
    assign cap_flag = st_q.flag;
    assign ovr_flag = st_q.ovr;

endmodule

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W  = TCC_CNT_W,
    parameter int FILT_W = TCC_FILT_W,
    parameter int PSC_W  = TCC_PSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              pin_own,
    input  logic              pin_partner,
    input  logic              trig_in,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic              cfg_pol,
    input  logic [1:0]        cfg_src,
    input  logic [PSC_W-1:0]  cfg_psc,
    input  logic              cfg_cap_en,
    input  logic              rd_strobe,
    input  logic              ovr_clr,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cap_flag,
    output logic              ovr_flag,
    output logic              trig_out
);

    localparam int DIV_W = (2 ** PSC_W) - 1;

    logic [TCC_NUM_IN-1:0] pins;
    logic [TCC_NUM_IN-1:0] lvl;
    logic [TCC_NUM_IN-1:0] rise;
    logic [TCC_NUM_IN-1:0] fall;
    logic [TCC_NUM_IN-1:0] edge_sel;
    src_e                  src;
    logic                  evt_raw;
    logic                  cap_active;
    logic                  psc_evt;
    logic                  cap_fire;
    logic [DIV_W-1:0]      psc_cnt;

    always_comb begin
        pins              = '0;
        pins[PIN_OWN]     = pin_own;
        pins[PIN_PARTNER] = pin_partner;
    end

    for (genvar i = 0; i < TCC_NUM_IN; i++) begin : g_in
        tcc_in_filter #(
            .FILT_W (FILT_W)
        ) u_flt (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_tick (sample_tick),
            .pin         (pins[i]),
            .cfg_filt    (cfg_filt),
            .lvl         (lvl[i]),
            .rise        (rise[i]),
            .fall        (fall[i])
        );
        assign edge_sel[i] = cfg_pol ? fall[i] : rise[i];
    end

    assign src = src_e'(cfg_src);

    always_comb begin
        unique case (src)
            SRC_OWN:     evt_raw = edge_sel[PIN_OWN];
            SRC_PARTNER: evt_raw = edge_sel[PIN_PARTNER];
            SRC_TRIG:    evt_raw = trig_in;
            default:     evt_raw = 1'b0;
        endcase
    end

    assign cap_active = cfg_cap_en && (src != SRC_OUTPUT);
    assign psc_evt    = evt_raw && cap_active;

    tcc_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!cap_active),
        .evt     (psc_evt),
        .cfg_psc (cfg_psc),
        .fire    (cap_fire),
        .ev_cnt  (psc_cnt)
    );

    tcc_capture_reg #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (cap_fire),
        .cnt_val   (cnt_val),
        .rd_strobe (rd_strobe),
        .ovr_clr   (ovr_clr),
        .cap_val   (cap_val),
        .cap_flag  (cap_flag),
        .ovr_flag  (ovr_flag)
    );

    assign trig_out = edge_sel[PIN_OWN];

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            cfg_src,
    input logic                  cfg_cap_en,
    input logic                  rd_strobe,
    input logic [CNT_W-1:0]      cap_val,
    input logic                  cap_flag,
    input logic                  ovr_flag,
    input logic                  trig_out,
    input logic                  cap_fire,
    input logic [(2**PSC_W)-2:0] psc_cnt
);

    a_r6_no_capture_output_mode : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src == 2'b00) |-> !cap_fire);

    a_r7_no_capture_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cap_en |-> !cap_fire);

    a_r5_psc_cleared : assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cap_en || cfg_src == 2'b00) |=> (psc_cnt == '0));

    a_r8_stable_during_read : assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> $stable(cap_val));

    a_r9_flag_on_update : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> cap_flag);

    a_r10_ovr_needs_flag : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));

    a_r11_trig_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

endmodule

bind tmr_capture_chan tcc_checker #(
    .CNT_W (CNT_W),
    .PSC_W (PSC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_src    (cfg_src),
    .cfg_cap_en (cfg_cap_en),
    .rd_strobe  (rd_strobe),
    .cap_val    (cap_val),
    .cap_flag   (cap_flag),
    .ovr_flag   (ovr_flag),
    .trig_out   (trig_out),
    .cap_fire   (cap_fire),
    .psc_cnt    (psc_cnt)
);

// File: tb/tmr_capture_chan_tb.sv
module tmr_capture_chan_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [1:0]  tick_ph = 2'd0;
    logic        sample_tick;
    logic        pin_own = 1'b0;
    logic        pin_partner = 1'b0;
    logic        trig_in = 1'b0;
    logic [15:0] cnt = 16'd0;
    logic [3:0]  cfg_filt = 4'd0;
    logic        cfg_pol = 1'b0;
    logic [1:0]  cfg_src = 2'b01;
    logic [1:0]  cfg_psc = 2'b00;
    logic        cfg_cap_en = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag;
    logic        ovr_flag;
    logic        trig_out;

    int n_cmp = 0;
    int n_err = 0;
    int trig_seen = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cnt <= 16'd0;
        else        cnt <= cnt + 16'd1;
    end

    always @(negedge clk) begin
        tick_ph <= (tick_ph == 2'd2) ? 2'd0 : tick_ph + 2'd1;
        if (trig_out) trig_seen <= trig_seen + 1;
    end

    assign sample_tick = !slow_tick || (tick_ph == 2'd0);

    tmr_capture_chan u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .pin_own     (pin_own),
        .pin_partner (pin_partner),
        .trig_in     (trig_in),
        .cnt_val     (cnt),
        .cfg_filt    (cfg_filt),
        .cfg_pol     (cfg_pol),
        .cfg_src     (cfg_src),
        .cfg_psc     (cfg_psc),
        .cfg_cap_en  (cfg_cap_en),
        .rd_strobe   (rd_strobe),
        .ovr_clr     (ovr_clr),
        .cap_val     (cap_val),
        .cap_flag    (cap_flag),
        .ovr_flag    (ovr_flag),
        .trig_out    (trig_out)
    );

    function automatic int div_of(input logic [1:0] p);
        return 1 << p;
    endfunction

    function automatic int filt_len(input logic [3:0] f);
        return int'(f) + 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Trigger event; returns the counter value of the trigger cycle. Ends after visibility.
    task automatic trig_event(output logic [15:0] c);
        trig_in = 1'b1;
        c = cnt;
        cyc(1);
        trig_in = 1'b0;
        cyc(2);
    endtask

    // Pin change; returns the counter value expected in a capture caused by it.
    task automatic drive_pin(input bit partner, input logic v, output logic [15:0] e);
        int n;
        logic [15:0] c;
        n = filt_len(cfg_filt);
        if (partner) pin_partner = v;
        else         pin_own = v;
        c = cnt;
        e = c + 16'(2 + n);
        cyc(n + 5);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        cyc(1);
        rd_strobe = 1'b0;
        cyc(1);
    endtask

    task automatic do_ovr_clr();
        ovr_clr = 1'b1;
        cyc(1);
        ovr_clr = 1'b0;
        cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog expired before the end of the run");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] e;
        logic [15:0] c;
        logic [15:0] lv;
        int          t0;
        bit          flag_m;
        bit          ovr_m;
        int          pcnt_m;

        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R12 reset state
        chk("R12 cap_val", 32'(cap_val), 32'd0);
        chk("R12 cap_flag", 32'(cap_flag), 32'd0);
        chk("R12 ovr_flag", 32'(ovr_flag), 32'd0);
        chk("R12 trig_out", 32'(trig_out), 32'd0);

        // R1/R3/R8: own pin, filter off, rising edge
        drive_pin(1'b0, 1'b1, e);
        chk("R8 own pin capture value", 32'(cap_val), 32'(e));
        chk("R9 flag set", 32'(cap_flag), 32'd1);
        lv = cap_val;
        cyc(3);
        chk("R9 flag held until read", 32'(cap_flag), 32'd1);
        do_read();
        chk("R9 read clears flag", 32'(cap_flag), 32'd0);

        // R2: falling polarity
        cfg_pol = 1'b1;
        cyc(1);
        drive_pin(1'b0, 1'b0, e);
        chk("R2 falling edge capture", 32'(cap_val), 32'(e));
        lv = cap_val;
        do_read();
        drive_pin(1'b0, 1'b1, e);
        chk("R2 rising edge ignored flag", 32'(cap_flag), 32'd0);
        chk("R2 rising edge ignored value", 32'(cap_val), 32'(lv));
        cfg_pol = 1'b0;
        cyc(1);
        drive_pin(1'b0, 1'b0, e);
        chk("R2 falling ignored with pol 0", 32'(cap_flag), 32'd0);

        // R1: filter length 4, glitch of 3 samples ignored
        cfg_filt = 4'd3;
        cyc(1);
        t0 = trig_seen;
        pin_own = 1'b1;
        cyc(3);
        pin_own = 1'b0;
        cyc(10);
        chk("R1 short glitch no capture", 32'(cap_flag), 32'd0);
        chk("R1 short glitch no trigger", 32'(trig_seen), 32'(t0));
        drive_pin(1'b0, 1'b1, e);
        chk("R1 filtered capture value", 32'(cap_val), 32'(e));
        chk("R1 filtered capture flag", 32'(cap_flag), 32'd1);
        do_read();
        drive_pin(1'b0, 1'b0, e);

        // R1: strobe every third clock, filter length 2
        cfg_filt = 4'd1;
        slow_tick = 1'b1;
        cyc(2);
        pin_own = 1'b1;
        cyc(2);
        pin_own = 1'b0;
        cyc(12);
        chk("R1 glitch between strobes ignored", 32'(cap_flag), 32'd0);
        pin_own = 1'b1;
        cyc(14);
        chk("R1 held level captured with slow strobe", 32'(cap_flag), 32'd1);
        do_read();
        pin_own = 1'b0;
        cyc(14);
        slow_tick = 1'b0;
        cfg_filt = 4'd0;
        cyc(2);
        chk("R1 falling not captured", 32'(cap_flag), 32'd0);

        // R3/R11: partner source
        cfg_src = 2'b10;
        cyc(1);
        lv = cap_val;
        t0 = trig_seen;
        drive_pin(1'b0, 1'b1, e);
        chk("R3 own pin ignored with partner source", 32'(cap_flag), 32'd0);
        chk("R11 trig_out pulses for own pin", 32'(trig_seen), 32'(t0 + 1));
        drive_pin(1'b1, 1'b1, e);
        chk("R3 partner capture value", 32'(cap_val), 32'(e));
        chk("R11 no trig_out for partner pin", 32'(trig_seen), 32'(t0 + 1));
        do_read();
        drive_pin(1'b0, 1'b0, e);
        drive_pin(1'b1, 1'b0, e);

        // R6/R11: output mode
        cfg_src = 2'b00;
        cyc(1);
        lv = cap_val;
        trig_event(c);
        chk("R6 output mode no capture", 32'(cap_flag), 32'd0);
        chk("R6 output mode value kept", 32'(cap_val), 32'(lv));
        t0 = trig_seen;
        drive_pin(1'b0, 1'b1, e);
        chk("R11 trig_out in output mode", 32'(trig_seen), 32'(t0 + 1));
        chk("R6 own pin in output mode no capture", 32'(cap_flag), 32'd0);
        drive_pin(1'b0, 1'b0, e);

        // R7: capture disabled
        cfg_src = 2'b11;
        cfg_cap_en = 1'b0;
        cyc(1);
        trig_event(c);
        chk("R7 disabled no capture", 32'(cap_flag), 32'd0);
        chk("R7 disabled value kept", 32'(cap_val), 32'(lv));
        cfg_cap_en = 1'b1;
        cyc(1);

        // R3/R8: trigger source value and read deferral
        trig_event(c);
        chk("R3 trigger capture value", 32'(cap_val), 32'(c));
        do_read();
        lv = cap_val;
        trig_in = 1'b1;
        c = cnt;
        cyc(1);
        trig_in = 1'b0;
        rd_strobe = 1'b1;
        cyc(1);
        rd_strobe = 1'b0;
        chk("R8 value held during read", 32'(cap_val), 32'(lv));
        chk("R8 flag clear during deferred move", 32'(cap_flag), 32'd0);
        cyc(1);
        chk("R8 deferred value arrives", 32'(cap_val), 32'(c));
        chk("R9 deferred flag set", 32'(cap_flag), 32'd1);
        do_read();

        // R10: overcapture
        trig_event(c);
        chk("R10 no ovr on first", 32'(ovr_flag), 32'd0);
        trig_event(c);
        chk("R10 ovr on second", 32'(ovr_flag), 32'd1);
        chk("R10 latest value", 32'(cap_val), 32'(c));
        do_read();
        chk("R10 ovr survives read", 32'(ovr_flag), 32'd1);
        do_ovr_clr();
        chk("R10 ovr cleared", 32'(ovr_flag), 32'd0);

        // R5: prescaler clear by enable and by division change
        cfg_psc = 2'b11;
        cyc(1);
        for (int i = 0; i < 3; i++) trig_event(c);
        chk("R4 three of eight no capture", 32'(cap_flag), 32'd0);
        cfg_cap_en = 1'b0;
        cyc(1);
        cfg_cap_en = 1'b1;
        cyc(1);
        for (int i = 0; i < 7; i++) trig_event(c);
        chk("R5 enable clear restarts count", 32'(cap_flag), 32'd0);
        trig_event(c);
        chk("R5 eighth after clear captures", 32'(cap_flag), 32'd1);
        chk("R5 eighth value", 32'(cap_val), 32'(c));
        do_read();
        for (int i = 0; i < 5; i++) trig_event(c);
        cfg_psc = 2'b10;
        cyc(2);
        for (int i = 0; i < 3; i++) trig_event(c);
        chk("R5 division change restarts count", 32'(cap_flag), 32'd0);
        trig_event(c);
        chk("R5 fourth after change captures", 32'(cap_val), 32'(c));
        do_read();

        // R4 random: trigger source, mixed divisions, reads and clears
        cfg_psc = 2'b00;
        cyc(2);
        flag_m = 1'b0;
        ovr_m = ovr_flag;
        pcnt_m = 0;
        lv = cap_val;
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(7) == 0) begin
                logic [1:0] np;
                np = 2'($urandom_range(3));
                if (np != cfg_psc) pcnt_m = 0;
                cfg_psc = np;
                cyc(1);
            end
            if ($urandom_range(9) == 0) begin
                cfg_cap_en = 1'b0;
                cyc(1);
                cfg_cap_en = 1'b1;
                cyc(1);
                pcnt_m = 0;
            end
            trig_event(c);
            if (pcnt_m == div_of(cfg_psc) - 1) begin
                pcnt_m = 0;
                if (flag_m) ovr_m = 1'b1;
                flag_m = 1'b1;
                lv = c;
            end else begin
                pcnt_m++;
            end
            chk("R4 random value", 32'(cap_val), 32'(lv));
            chk("R9 random flag", 32'(cap_flag), 32'(flag_m));
            chk("R10 random ovr", 32'(ovr_flag), 32'(ovr_m));
            if ($urandom_range(2) == 0) begin
                do_read();
                flag_m = 1'b0;
            end
            if ($urandom_range(5) == 0) begin
                do_ovr_clr();
                ovr_m = 1'b0;
            end
        end

        summary();
        $finish;
    end

endmodule